// File: doc/BRIEF.md
# Width-Aware Register Merge Unit

This unit keeps the accumulator and the two index registers of a processor core whose operand width can be switched between 8 and 16 bits at run time. It also keeps the three mode bits that control that switching: the accumulator-width flag, the index-width flag and the emulation flag. For each mode bit, 1 selects the narrow 8-bit width and 0 selects the full 16-bit width. A write to a register passes through masks that come from these bits. A narrow accumulator write replaces only the low byte and leaves the hidden high byte in place. A narrow index write is clipped to 8 bits.

The surrounding sequencer issues one register load per cycle through a target select and a 16-bit value. It changes the mode bits with a separate strobe. The unit also reports how far a result must be shifted to bring its sign bit to flag position, one shift for the accumulator side and one for the index side. It also reports the sign bit of the most recent load, which a flag block downstream consumes.

Top module: `wreg_merge_unit`

## Requirements
- R1: After reset the accumulator, X and Y hold 0x0000, all three mode bits read 1, both shifts read 0 and the sign output reads 0.
- R2: The target select codes are 0 = none, 1 = accumulator, 2 = X, 3 = Y. When the flag strobe is high, the three mode bits take the supplied values at the edge. If the supplied emulation bit is 1, both width bits become 1 whatever values were supplied for them.
- R3: With the accumulator-width bit at 1, an accumulator load of Q gives (A AND 0xFF00) OR (Q AND 0x00FF). The high byte is kept.
- R4: With the accumulator-width bit at 0, an accumulator load replaces all 16 bits with Q.
- R5: An index load stores Q AND 0x00FF when the index-width bit is 1, and stores Q unchanged when it is 0.
- R6: While the index-width bit is 1, the high bytes of X and Y are zero. A change of that bit from 0 to 1 clears both high bytes at the same edge.
- R7: The accumulator shift reads 8 when the accumulator-width bit is 0 and reads 0 when it is 1. The index shift follows the index-width bit in the same way.
- R8: One cycle after a load, the sign output equals bit 15 of the stored value when the width in force was 16 bits, and bit 7 when it was 8 bits. Without a load, the sign output holds its value.
- R9: A load in the same cycle as a flag strobe uses the widths held before that edge. The R6 clearing still applies to the stored index value.
- R10: A register that the select does not target keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flg_we | input | 1 | Strobe to write the mode bits |
| flg_m | input | 1 | New accumulator-width bit (1 = 8-bit) |
| flg_x | input | 1 | New index-width bit (1 = 8-bit) |
| flg_e | input | 1 | New emulation bit |
| ld_sel | input | 2 | Load target: 0 none, 1 accumulator, 2 X, 3 Y |
| ld_val | input | 16 | Value to load |
| acc_q | output | 16 | Accumulator contents |
| idx_x_q | output | 16 | X register contents |
| idx_y_q | output | 16 | Y register contents |
| m_flag | output | 1 | Current accumulator-width bit |
| x_flag | output | 1 | Current index-width bit |
| e_flag | output | 1 | Current emulation bit |
| acc_shift | output | 4 | Sign-alignment shift for the accumulator side (0 or 8) |
| idx_shift | output | 4 | Sign-alignment shift for the index side (0 or 8) |
| res_sign | output | 1 | Sign bit of the last loaded value |

## Verification
The hardest case to reach is the same edge that narrows the index width and loads an index register. In that cycle the load is merged at the old 16-bit width, and the result is then clipped by the new narrow mask. The stimulus table reaches this case by first widening the index registers, then raising the emulation bit in the same cycle as a full-width X load. It also tries to clear the width bits while emulation stays set, so that the forcing rule is seen on the accumulator's kept high byte.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
  parameter int DATA_W = 16;
  localparam int HALF_W = DATA_W / 2;
  localparam int SHIFT_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ACC   = 2'd1,
    SEL_IDX_X = 2'd2,
    SEL_IDX_Y = 2'd3
  } ld_sel_e;

  // Bits left untouched by an accumulator load.
  function automatic logic [DATA_W-1:0] keep_mask(input logic narrow);
    keep_mask = narrow ? {{HALF_W{1'b1}}, {HALF_W{1'b0}}} : '0;
  endfunction

  // Bits replaced by a load.
  function automatic logic [DATA_W-1:0] write_mask(input logic narrow);
    write_mask = narrow ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic narrow);
    merge = (old_v & keep_mask(narrow)) | (new_v & write_mask(narrow));
  endfunction

  function automatic logic [SHIFT_W-1:0] sign_shift(input logic narrow);
    sign_shift = narrow ? SHIFT_W'(0) : SHIFT_W'(HALF_W);
  endfunction

  function automatic logic sign_of(input logic [DATA_W-1:0] v, input logic narrow);
    sign_of = narrow ? v[HALF_W-1] : v[DATA_W-1];
  endfunction
endpackage

// File: rtl/wmu_flags.sv
module wmu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flg_we,
  input  logic flg_m,
  input  logic flg_x,
  input  logic flg_e,
  output logic m_q,
  output logic x_q,
  output logic e_q,
  output logic x_nxt,
  output logic x_narrow_evt
);
  logic m_nxt, e_nxt;

  always_comb begin
    m_nxt = m_q;
    x_nxt = x_q;
    e_nxt = e_q;
    if (flg_we) begin
      e_nxt = flg_e;
      m_nxt = flg_e | flg_m;
      x_nxt = flg_e | flg_x;
    end
  end

  assign x_narrow_evt = x_nxt & ~x_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q <= 1'b1;
      x_q <= 1'b1;
      e_q <= 1'b1;
    end else begin
      m_q <= m_nxt;
      x_q <= x_nxt;
      e_q <= e_nxt;
    end
  end
endmodule

// File: rtl/wmu_regs.sv
module wmu_regs
  import wmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              m_cur,
  input  logic              x_cur,
  input  logic              x_nxt,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] idx_q [2],
  output logic              sign_q
);
  localparam int NUM_IDX = 2;

  logic              acc_we;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] idx_merged [NUM_IDX];
  logic [NUM_IDX-1:0] idx_we;
  logic              sign_d;

  assign acc_we = (ld_sel == SEL_ACC);
  assign acc_d  = acc_we ? merge(acc_q, ld_val, m_cur) : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
    logic [DATA_W-1:0] idx_d;
    assign idx_we[i]     = (ld_sel == 2'(SEL_IDX_X + i));
    assign idx_merged[i] = ld_val & write_mask(x_cur);
    assign idx_d = (idx_we[i] ? idx_merged[i] : idx_q[i]) & write_mask(x_nxt);
    always_ff @(posedge clk) begin
      if (!rst_n) idx_q[i] <= '0;
      else        idx_q[i] <= idx_d;
    end
  end

  always_comb begin
    sign_d = sign_q;
    if (acc_we)         sign_d = sign_of(acc_d, m_cur);
    else if (idx_we[0]) sign_d = sign_of(idx_merged[0], x_cur);
    else if (idx_we[1]) sign_d = sign_of(idx_merged[1], x_cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sign_q <= 1'b0;
    else        sign_q <= sign_d;
  end
endmodule

// File: rtl/wreg_merge_unit.sv
module wreg_merge_unit
  import wmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flg_we,
  input  logic              flg_m,
  input  logic              flg_x,
  input  logic              flg_e,
  input  logic [1:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] idx_x_q,
  output logic [DATA_W-1:0] idx_y_q,
  output logic              m_flag,
  output logic              x_flag,
  output logic              e_flag,
  output logic [SHIFT_W-1:0] acc_shift,
  output logic [SHIFT_W-1:0] idx_shift,
  output logic              res_sign
);
  logic              x_nxt;
  logic              x_narrow_evt;
  logic [DATA_W-1:0] idx_q [2];

  wmu_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .flg_we       (flg_we),
    .flg_m        (flg_m),
    .flg_x        (flg_x),
    .flg_e        (flg_e),
    .m_q          (m_flag),
    .x_q          (x_flag),
    .e_q          (e_flag),
    .x_nxt        (x_nxt),
    .x_narrow_evt (x_narrow_evt)
  );

  wmu_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_sel (ld_sel),
    .ld_val (ld_val),
    .m_cur  (m_flag),
    .x_cur  (x_flag),
    .x_nxt  (x_nxt),
    .acc_q  (acc_q),
    .idx_q  (idx_q),
    .sign_q (res_sign)
  );

  assign idx_x_q   = idx_q[0];
  assign idx_y_q   = idx_q[1];
  assign acc_shift = sign_shift(m_flag);
  assign idx_shift = sign_shift(x_flag);
endmodule

// File: rtl/wmu_checker.sv
module wmu_checker
  import wmu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ld_sel,
  input logic [DATA_W-1:0] ld_val,
  input logic [DATA_W-1:0] acc_q,
  input logic [DATA_W-1:0] idx_x_q,
  input logic [DATA_W-1:0] idx_y_q,
  input logic              m_flag,
  input logic              x_flag,
  input logic              e_flag,
  input logic [SHIFT_W-1:0] acc_shift,
  input logic              res_sign,
  input logic              x_narrow_evt
);
  assert_emul_forces_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    e_flag |-> (m_flag && x_flag));

  assert_acc_high_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == SEL_ACC && m_flag) |=> acc_q[DATA_W-1:HALF_W] == $past(acc_q[DATA_W-1:HALF_W]));

  assert_acc_full_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == SEL_ACC && !m_flag) |=> acc_q == $past(ld_val));

  assert_idx_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_flag |-> (idx_x_q[DATA_W-1:HALF_W] == '0 && idx_y_q[DATA_W-1:HALF_W] == '0));

  assert_narrow_event_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_narrow_evt |=> (x_flag && idx_x_q[DATA_W-1:HALF_W] == '0));

  assert_shift_values_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_shift == SHIFT_W'(0)) || (acc_shift == SHIFT_W'(HALF_W)));

  assert_sign_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == SEL_NONE) |=> $stable(res_sign));

  assert_acc_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel != SEL_ACC) |=> $stable(acc_q));
endmodule

bind wreg_merge_unit wmu_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_sel       (ld_sel),
  .ld_val       (ld_val),
  .acc_q        (acc_q),
  .idx_x_q      (idx_x_q),
  .idx_y_q      (idx_y_q),
  .m_flag       (m_flag),
  .x_flag       (x_flag),
  .e_flag       (e_flag),
  .acc_shift    (acc_shift),
  .res_sign     (res_sign),
  .x_narrow_evt (x_narrow_evt)
);

// File: tb/wreg_merge_unit_tb.sv
module wreg_merge_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flg_we = 1'b0, flg_m = 1'b0, flg_x = 1'b0, flg_e = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [15:0] ld_val = 16'h0;
  logic [15:0] acc_q, idx_x_q, idx_y_q;
  logic        m_flag, x_flag, e_flag, res_sign;
  logic [3:0]  acc_shift, idx_shift;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wreg_merge_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flg_we(flg_we), .flg_m(flg_m), .flg_x(flg_x),
    .flg_e(flg_e), .ld_sel(ld_sel), .ld_val(ld_val), .acc_q(acc_q),
    .idx_x_q(idx_x_q), .idx_y_q(idx_y_q), .m_flag(m_flag), .x_flag(x_flag),
    .e_flag(e_flag), .acc_shift(acc_shift), .idx_shift(idx_shift), .res_sign(res_sign)
  );

  // fw fm fx fe | sel | val | exp A | exp X | exp Y | exp sign | exp m x e
  localparam logic [73:0] VEC [16] = '{
    {4'b1000, 2'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 3'b000},
    {4'b0000, 2'd1, 16'h1234, 16'h1234, 16'h0000, 16'h0000, 1'b0, 3'b000},
    {4'b0000, 2'd2, 16'h8001, 16'h1234, 16'h8001, 16'h0000, 1'b1, 3'b000},
    {4'b0000, 2'd3, 16'h7F80, 16'h1234, 16'h8001, 16'h7F80, 1'b0, 3'b000},
    {4'b1100, 2'd0, 16'h0000, 16'h1234, 16'h8001, 16'h7F80, 1'b0, 3'b100},
    {4'b0000, 2'd1, 16'hABCD, 16'h12CD, 16'h8001, 16'h7F80, 1'b1, 3'b100},
    {4'b0000, 2'd1, 16'h0055, 16'h1255, 16'h8001, 16'h7F80, 1'b0, 3'b100},
    {4'b1110, 2'd0, 16'h0000, 16'h1255, 16'h0001, 16'h0080, 1'b0, 3'b110},
    {4'b0000, 2'd2, 16'hFF90, 16'h1255, 16'h0090, 16'h0080, 1'b1, 3'b110},
    {4'b0000, 2'd3, 16'h1234, 16'h1255, 16'h0090, 16'h0034, 1'b0, 3'b110},
    {4'b1000, 2'd0, 16'h0000, 16'h1255, 16'h0090, 16'h0034, 1'b0, 3'b000},
    {4'b0000, 2'd1, 16'hF000, 16'hF000, 16'h0090, 16'h0034, 1'b1, 3'b000},
    {4'b1001, 2'd2, 16'h1111, 16'hF000, 16'h0011, 16'h0034, 1'b0, 3'b111},
    {4'b1001, 2'd1, 16'h0080, 16'hF080, 16'h0011, 16'h0034, 1'b1, 3'b111},
    {4'b1000, 2'd1, 16'h0102, 16'hF002, 16'h0011, 16'h0034, 1'b0, 3'b000},
    {4'b0000, 2'd0, 16'hFFFF, 16'hF002, 16'h0011, 16'h0034, 1'b0, 3'b000}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check("R1", {tag, " acc"}, acc_q, 16'h0);
    check("R1", {tag, " X"}, idx_x_q, 16'h0);
    check("R1", {tag, " Y"}, idx_y_q, 16'h0);
    check("R1", {tag, " flags"}, {13'd0, m_flag, x_flag, e_flag}, 16'h7);
    check("R1", {tag, " shifts"}, {8'd0, acc_shift, idx_shift}, 16'h0);
    check("R1", {tag, " sign"}, {15'd0, res_sign}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("after reset");

    for (int i = 0; i < 16; i++) begin
      logic [73:0] v;
      v = VEC[i];
      flg_we = v[73]; flg_m = v[72]; flg_x = v[71]; flg_e = v[70];
      ld_sel = v[69:68]; ld_val = v[67:52];
      @(negedge clk);
      // R3 R4 R9: accumulator merge; R10: untouched registers
      check("R3/R4/R9/R10", $sformatf("vec%0d acc", i), acc_q, v[51:36]);
      // R5 R6: index masking and high-byte clearing
      check("R5/R6/R10", $sformatf("vec%0d X", i), idx_x_q, v[35:20]);
      check("R5/R6/R10", $sformatf("vec%0d Y", i), idx_y_q, v[19:4]);
      check("R8", $sformatf("vec%0d sign", i), {15'd0, res_sign}, {15'd0, v[3]});
      check("R2", $sformatf("vec%0d flags", i), {13'd0, m_flag, x_flag, e_flag}, {13'd0, v[2:0]});
      check("R7", $sformatf("vec%0d acc_shift", i), {12'd0, acc_shift}, v[2] ? 16'd0 : 16'd8);
      check("R7", $sformatf("vec%0d idx_shift", i), {12'd0, idx_shift}, v[1] ? 16'd0 : 16'd8);
    end

    // R6 directed: wide Y value, then narrow only the index side
    flg_we = 1'b1; flg_m = 1'b0; flg_x = 1'b0; flg_e = 1'b0; ld_sel = 2'd3; ld_val = 16'hA5C3;
    @(negedge clk);
    check("R5", "wide Y load", idx_y_q, 16'hA5C3);
    flg_x = 1'b1; ld_sel = 2'd0;
    @(negedge clk);
    check("R6", "Y high cleared on narrowing", idx_y_q, 16'h00C3);
    check("R6", "X high cleared on narrowing", idx_x_q, 16'h0011);
    check("R4", "acc still wide", {12'd0, acc_shift}, 16'd8);
    flg_we = 1'b0;

    // R1 directed: reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("mid-run reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule